// File: doc/BRIEF.md
# Synchronous burst memory clock controller

This block generates the memory clock for synchronous burst reads from pseudo-static RAM or burst-capable NOR flash, and it sequences each burst. A divider built from a phase counter derives the memory clock from the host clock. The division ratio is programmable from 2 to 16. The divided clock is high for the lower half of the ratio, rounded down, and low for the rest of the period. The clock runs in one of two modes. In gated mode it toggles only while a burst is in progress. In continuous mode it runs all the time. Continuous mode takes effect only when the bank-synchronous flag is also set. Otherwise the block falls back to gated behaviour.

A burst begins with a start pulse. It then runs through an address phase, a latency phase of a programmable number of memory clocks, and a data phase that takes one beat per memory clock rising edge. A beat is held back while the memory's wait input is high. The burst ends with a host-cycle turnaround. The state machine has six states. IDLE goes to ALIGN on start in continuous mode, or to ADDR on start in gated mode. ALIGN goes to ADDR on a memory clock falling edge. ADDR goes to LAT on the falling edge that follows the address rising edge. LAT goes to DATA on the rising edge that exhausts the latency count. DATA goes to TURN, or to IDLE if the turnaround is zero, on the falling edge after the last accepted beat. TURN goes to IDLE when its countdown expires.

Configuration inputs are expected to stay stable while a burst is in progress.

Top module: `sync_burst_clkctl`

## Requirements
- R1: The memory clock period is R host cycles, where R is `cfg_ratio` clamped into 2..16 (values below 2 act as 2, above 16 as 16). The clock is high for floor(R/2) host cycles of each period.
- R2: With `cfg_continuous` low, `mem_clk` stays low whenever `busy` is low and toggles only during a burst.
- R3: With both `cfg_continuous` and `cfg_bank_sync` high, `mem_clk` runs while idle. Consecutive rising edges stay exactly R host cycles apart across the start and end of a burst, so the divider is never restarted.
- R4: With `cfg_continuous` high but `cfg_bank_sync` low, the clock behaves as in R2.
- R5: `mem_adv_n` and `mem_cs_n` first go low while `mem_clk` is low. In continuous mode this happens only after a falling edge. `mem_adv_n` stays low across exactly one `mem_clk` rising edge, called the address edge.
- R6: With L = `cfg_latency` + 2 (field value 0 means 2, 15 means 17), the first beat is sampled at the L-th rising edge after the address edge.
- R7: In the data phase each rising edge without wait samples `mem_rdata` on the host cycle that produces that edge. `beat_valid` pulses for one host cycle on the next cycle, with the sampled word on `beat_data`.
- R8: When `mem_wait` is high at a sampling edge, the data is discarded and the beat count does not advance.
- R9: A burst delivers exactly `burst_beats` beats (0 is taken as 1) and no more.
- R10: After the cycle in which the last `beat_valid` appears, `busy` stays high for floor(R/2) + `cfg_turn` more host cycles, counting that cycle. `mem_cs_n` rises only while `mem_clk` is low.
- R11: `burst_start` is ignored while `busy` is high: no second address phase and no extra beats.
- R12: During reset `mem_clk` and `beat_valid` are low, `mem_cs_n` and `mem_adv_n` are high, and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio | input | RATIO_W | Host cycles per memory clock (clamped 2..16) |
| cfg_latency | input | LAT_W | First-data latency minus two, in memory clocks |
| cfg_turn | input | TURN_W | Turnaround length in host cycles |
| cfg_continuous | input | 1 | Request a free-running memory clock |
| cfg_bank_sync | input | 1 | First bank is in synchronous mode; enables continuous clock |
| burst_start | input | 1 | One-cycle pulse that starts a burst |
| burst_beats | input | BEAT_W | Number of beats in the burst (0 taken as 1) |
| mem_wait | input | 1 | Memory not ready, active high |
| mem_rdata | input | DATA_W | Read data from memory |
| mem_clk | output | 1 | Divided memory clock |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| beat_valid | output | 1 | One-cycle strobe for a captured beat |
| beat_data | output | DATA_W | Captured beat data |
| busy | output | 1 | Burst in progress, including turnaround |

## Verification
A wrong divider count or a wrong park value shows up at the pins within one memory clock period. It appears as an edge spacing or high time that differs from R. In gated mode it can also appear as a pulse on `mem_clk` while `busy` is low. A latency or beat counter that is off by one changes the word carried by the first or a later `beat_valid`. This is because the memory model returns the index of the edge at which it is read. The difference is visible within one memory clock of the expected beat. A mistimed state exit shows up on the turnaround count after the last beat, or as `mem_adv_n` spanning zero or two rising edges. Both are visible before the next burst can begin.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ALIGN = 3'd1,
        ST_ADDR  = 3'd2,
        ST_LAT   = 3'd3,
        ST_DATA  = 3'd4,
        ST_TURN  = 3'd5
    } sbc_state_e;

endpackage

// File: rtl/sbc_clkdiv.sv
module sbc_clkdiv #(
    parameter int RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               mem_clk,
    output logic               rise_tick,
    output logic               fall_tick
);

    logic [RATIO_W-1:0] cnt_q;
    logic [RATIO_W-1:0] cnt_n;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] last;
    logic               mem_clk_q;

    // Phase counter: 0..half-1 is the high phase, half..ratio-1 the low phase.
    // When disabled it parks at half-1 so that the next enable starts a low phase.
    always_comb begin
        half      = ratio >> 1;
        last      = ratio - RATIO_W'(1);
        rise_tick = en && (cnt_q >= last);
        fall_tick = en && (cnt_q == half - RATIO_W'(1));
        if (!en) begin
            cnt_n = half - RATIO_W'(1);
        end else if (cnt_q >= last) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt_q + RATIO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            mem_clk_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_n;
            mem_clk_q <= en && (cnt_n < half);
        end
    end

    assign mem_clk = mem_clk_q;

    // R1: a rise tick always produces a high clock on the next host cycle
    p_rise_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> mem_clk);

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int LAT_W  = 4,
    parameter int BEAT_W = 8,
    parameter int TURN_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BEAT_W-1:0] beats,
    input  logic [LAT_W-1:0]  lat,
    input  logic [TURN_W-1:0] turn,
    input  logic              cont_eff,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mem_wait,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              clk_req,
    output logic              cs_n,
    output logic              adv_n,
    output logic              busy,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data
);

    sbc_state_e        state_q;
    sbc_state_e        state_n;
    logic              edge_seen_q;
    logic [LAT_W-1:0]  lat_q;
    logic [BEAT_W-1:0] rem_q;
    logic [TURN_W-1:0] turn_q;
    logic              take_beat;
    logic              last_take;
    logic              beat_valid_q;
    logic [DATA_W-1:0] beat_data_q;

    assign take_beat = (state_q == ST_DATA) && rise_tick && !mem_wait && !edge_seen_q;
    assign last_take = take_beat && (rem_q == BEAT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next-state decode
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_n = cont_eff ? ST_ALIGN : ST_ADDR;
                end
            end
            ST_ALIGN: begin
                if (fall_tick) begin
                    state_n = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (edge_seen_q && fall_tick) begin
                    state_n = ST_LAT;
                end
            end
            ST_LAT: begin
                if (rise_tick && (lat_q == '0)) begin
                    state_n = ST_DATA;
                end
            end
            ST_DATA: begin
                if (edge_seen_q && fall_tick) begin
                    state_n = (turn == '0) ? ST_IDLE : ST_TURN;
                end
            end
            ST_TURN: begin
                if (turn_q == '0) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Counters and the edge flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_seen_q <= 1'b0;
            lat_q       <= '0;
            rem_q       <= '0;
            turn_q      <= '0;
        end else begin
            if (state_n != state_q) begin
                edge_seen_q <= 1'b0;
            end else if ((state_q == ST_ADDR && rise_tick) || last_take) begin
                edge_seen_q <= 1'b1;
            end

            if (state_q == ST_IDLE && start) begin
                rem_q <= (beats == '0) ? BEAT_W'(1) : beats;
            end else if (take_beat) begin
                rem_q <= rem_q - BEAT_W'(1);
            end

            if (state_q == ST_ADDR && state_n == ST_LAT) begin
                lat_q <= lat;
            end else if (state_q == ST_LAT && rise_tick && lat_q != '0) begin
                lat_q <= lat_q - LAT_W'(1);
            end

            if (state_q == ST_DATA && state_n == ST_TURN) begin
                turn_q <= turn - TURN_W'(1);
            end else if (state_q == ST_TURN && turn_q != '0) begin
                turn_q <= turn_q - TURN_W'(1);
            end
        end
    end

    // Beat capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_valid_q <= 1'b0;
            beat_data_q  <= '0;
        end else begin
            beat_valid_q <= take_beat;
            if (take_beat) begin
                beat_data_q <= mem_rdata;
            end
        end
    end

    assign beat_valid = beat_valid_q;
    assign beat_data  = beat_data_q;

    // Outputs from state
    always_comb begin
        cs_n    = 1'b1;
        adv_n   = 1'b1;
        clk_req = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ALIGN: clk_req = 1'b1;
            ST_ADDR: begin
                cs_n    = 1'b0;
                adv_n   = 1'b0;
                clk_req = 1'b1;
            end
            ST_LAT, ST_DATA: begin
                cs_n    = 1'b0;
                clk_req = 1'b1;
            end
            ST_TURN:  cs_n = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // R8: a waited sampling edge yields no beat
    p_wait_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && rise_tick && mem_wait) |=> !beat_valid);

    // R7: a beat only appears while the device is selected
    p_beat_selected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !cs_n);

    // R7: beat strobes are single-cycle pulses
    p_beat_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |=> !beat_valid);

endmodule

// File: rtl/sync_burst_clkctl.sv
module sync_burst_clkctl
    import sbc_pkg::*;
#(
    parameter int MIN_RATIO = 2,
    parameter int MAX_RATIO = 16,
    parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
    parameter int LAT_W     = 4,
    parameter int TURN_W    = 4,
    parameter int BEAT_W    = 8,
    parameter int DATA_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [LAT_W-1:0]   cfg_latency,
    input  logic [TURN_W-1:0]  cfg_turn,
    input  logic               cfg_continuous,
    input  logic               cfg_bank_sync,
    input  logic               burst_start,
    input  logic [BEAT_W-1:0]  burst_beats,
    input  logic               mem_wait,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_clk,
    output logic               mem_cs_n,
    output logic               mem_adv_n,
    output logic               beat_valid,
    output logic [DATA_W-1:0]  beat_data,
    output logic               busy
);

    localparam logic [RATIO_W-1:0] RATIO_LO = RATIO_W'(MIN_RATIO);
    localparam logic [RATIO_W-1:0] RATIO_HI = RATIO_W'(MAX_RATIO);

    logic               cont_eff;
    logic               clk_req;
    logic               div_en;
    logic               rise_tick;
    logic               fall_tick;
    logic [RATIO_W-1:0] ratio_eff;
    logic               cont_prev_q;

    always_comb begin
        if (cfg_ratio < RATIO_LO) begin
            ratio_eff = RATIO_LO;
        end else if (cfg_ratio > RATIO_HI) begin
            ratio_eff = RATIO_HI;
        end else begin
            ratio_eff = cfg_ratio;
        end
    end

    assign cont_eff = cfg_continuous && cfg_bank_sync;
    assign div_en   = cont_eff || clk_req;

    sbc_clkdiv #(
        .RATIO_W (RATIO_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (div_en),
        .ratio     (ratio_eff),
        .mem_clk   (mem_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    sbc_seq #(
        .LAT_W  (LAT_W),
        .BEAT_W (BEAT_W),
        .TURN_W (TURN_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (burst_start),
        .beats      (burst_beats),
        .lat        (cfg_latency),
        .turn       (cfg_turn),
        .cont_eff   (cont_eff),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .mem_wait   (mem_wait),
        .mem_rdata  (mem_rdata),
        .clk_req    (clk_req),
        .cs_n       (mem_cs_n),
        .adv_n      (mem_adv_n),
        .busy       (busy),
        .beat_valid (beat_valid),
        .beat_data  (beat_data)
    );

    // Mode history for the idle-clock check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_prev_q <= 1'b0;
        end else begin
            cont_prev_q <= cont_eff;
        end
    end

    // R5: address valid is raised into a low memory clock
    p_adv_clk_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_adv_n) |-> !mem_clk);

    // R2: gated clock is quiet whenever no burst is running
    p_gated_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_eff && !cont_prev_q && !busy) |-> !mem_clk);

    // R10: chip select is released only while the memory clock is low
    p_cs_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> !mem_clk);

endmodule

// File: tb/sync_burst_clkctl_test.sv
module sync_burst_clkctl_test;

    localparam int RATIO_W = 5;
    localparam int LAT_W   = 4;
    localparam int TURN_W  = 4;
    localparam int BEAT_W  = 8;
    localparam int DATA_W  = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [RATIO_W-1:0] cfg_ratio = RATIO_W'(4);
    logic [LAT_W-1:0]   cfg_latency = '0;
    logic [TURN_W-1:0]  cfg_turn = '0;
    logic               cfg_continuous = 1'b0;
    logic               cfg_bank_sync = 1'b0;
    logic               burst_start = 1'b0;
    logic [BEAT_W-1:0]  burst_beats = '0;
    logic               mem_wait = 1'b0;
    logic [DATA_W-1:0]  mem_rdata = '0;
    logic               mem_clk;
    logic               mem_cs_n;
    logic               mem_adv_n;
    logic               beat_valid;
    logic [DATA_W-1:0]  beat_data;
    logic               busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sync_burst_clkctl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_ratio      (cfg_ratio),
        .cfg_latency    (cfg_latency),
        .cfg_turn       (cfg_turn),
        .cfg_continuous (cfg_continuous),
        .cfg_bank_sync  (cfg_bank_sync),
        .burst_start    (burst_start),
        .burst_beats    (burst_beats),
        .mem_wait       (mem_wait),
        .mem_rdata      (mem_rdata),
        .mem_clk        (mem_clk),
        .mem_cs_n       (mem_cs_n),
        .mem_adv_n      (mem_adv_n),
        .beat_valid     (beat_valid),
        .beat_data      (beat_data),
        .busy           (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Edge index at which beat b is accepted: first unwaited edges from L on
    function automatic int exp_beat(input int L, input logic [63:0] wm, input int b);
        int c;
        c = 0;
        for (int j = L; j < 64; j++) begin
            if (!wm[j]) begin
                if (c == b) return j;
                c++;
            end
        end
        return -1;
    endfunction

    task automatic run_burst(input int rcfg, input int lat, input int trn, input int nb,
                             input bit cont, input bit bsync, input logic [63:0] wm,
                             input bit poke);
        int r, half, L, nbe, t, k, last_rise, int_bad, adv_rises, nseen;
        int post_busy, gviol, hi, idle_period, idle_high, idle_on, cons, extra_bv, extra_adv;
        int expd;
        bit ceff, prev_clk, adv_chk, seen_last, bv_prev, poked, poke_hold, rise;
        string gl;
        r    = (rcfg < 2) ? 2 : ((rcfg > 16) ? 16 : rcfg);
        half = r / 2;
        L    = lat + 2;
        nbe  = (nb == 0) ? 1 : nb;
        ceff = cont && bsync;
        gl   = (cont && !bsync) ? "R4" : "R2";

        @(negedge clk);
        cfg_ratio      = RATIO_W'(rcfg);
        cfg_latency    = LAT_W'(lat);
        cfg_turn       = TURN_W'(trn);
        cfg_continuous = cont;
        cfg_bank_sync  = bsync;
        mem_wait       = 1'b0;
        mem_rdata      = '0;
        repeat (2 * r + 4) @(negedge clk);

        // Idle window: clock shape or silence
        prev_clk = mem_clk; last_rise = -1; hi = 0;
        idle_period = -1; idle_high = -1; idle_on = 0;
        for (int i = 0; i < 3 * r + 2; i++) begin
            @(negedge clk);
            if (mem_clk && !prev_clk) begin
                if (last_rise >= 0 && idle_period < 0) idle_period = i - last_rise;
                last_rise = i;
            end
            if (mem_clk) begin
                hi++;
                idle_on++;
            end else begin
                if (prev_clk && idle_high < 0 && last_rise >= 0) idle_high = hi;
                hi = 0;
            end
            prev_clk = mem_clk;
        end
        if (ceff) begin
            check(idle_period == r, "R1 period", idle_period, r);
            check(idle_high == half, "R1 high time", idle_high, half);
            check(idle_on > 0, "R3 free-running while idle", idle_on, 1);
        end else begin
            check(idle_on == 0, {gl, " idle clock quiet"}, idle_on, 0);
        end

        // Burst
        @(negedge clk);
        burst_start = 1'b1;
        burst_beats = BEAT_W'(nb);
        t = 0; k = 0; last_rise = -1; int_bad = 0; adv_rises = 0; nseen = 0;
        post_busy = 0; gviol = 0; cons = 0;
        adv_chk = 0; seen_last = 0; bv_prev = 0; poked = 0; poke_hold = 0;
        prev_clk = mem_clk;
        while (t < 4000) begin
            @(negedge clk);
            t++;
            if (t == 1) burst_start = 1'b0;
            if (poke_hold) begin
                burst_start = 1'b0;
                poke_hold = 0;
            end
            rise = mem_clk && !prev_clk;
            prev_clk = mem_clk;
            if (rise) begin
                if (last_rise >= 0 && (t - last_rise) != r) int_bad++;
                last_rise = t;
            end
            if (!mem_adv_n && !adv_chk) begin
                adv_chk = 1;
                check(!mem_clk && !mem_cs_n, "R5 select raised into low clock", int'(mem_clk), 0);
            end
            if (rise && !mem_adv_n) adv_rises++;
            if (rise && !mem_adv_n && k == 0) k = 1;
            else if (rise && k > 0) k++;
            mem_rdata = DATA_W'(k);
            mem_wait  = (k > 0) ? wm[k & 63] : 1'b0;
            if (beat_valid) begin
                if (bv_prev) cons++;
                if (nseen < nbe) begin
                    expd = exp_beat(L, wm, nseen);
                    if (nseen == 0)
                        check(int'(beat_data) == expd, "R6 first beat edge", int'(beat_data), expd);
                    else if (wm != '0)
                        check(int'(beat_data) == expd, "R8 beat after wait", int'(beat_data), expd);
                    else
                        check(int'(beat_data) == expd, "R7 beat per edge", int'(beat_data), expd);
                end
                nseen++;
                if (nseen == nbe) seen_last = 1;
            end
            bv_prev = beat_valid;
            if (!ceff && !busy && mem_clk) gviol++;
            if (poke && !poked && k == 2) begin
                burst_start = 1'b1;
                poked = 1;
                poke_hold = 1;
            end
            if (seen_last) begin
                if (busy) post_busy++;
                else break;
            end
        end
        burst_start = 1'b0;
        mem_wait = 1'b0;

        check(nseen == nbe, "R9 beat count", nseen, nbe);
        check(post_busy == half + trn, "R10 turnaround", post_busy, half + trn);
        check(mem_cs_n, "R10 select released", int'(mem_cs_n), 1);
        check(adv_rises == 1, "R5 one address edge", adv_rises, 1);
        check(int_bad == 0, ceff ? "R3 edge spacing" : "R1 edge spacing", int_bad, 0);
        check(cons == 0, "R7 single-cycle strobe", cons, 0);
        if (!ceff) check(gviol == 0, {gl, " clock gated when idle"}, gviol, 0);

        // Afterwards: nothing more may happen
        extra_bv = 0; extra_adv = 0;
        for (int i = 0; i < 2 * r + 2; i++) begin
            @(negedge clk);
            if (beat_valid) extra_bv++;
            if (!mem_adv_n || busy) extra_adv++;
        end
        check(extra_bv == 0, "R9 no extra beats", extra_bv, 0);
        if (poke) check(extra_adv == 0, "R11 start ignored while busy", extra_adv, 0);
    endtask

    initial begin
        int ratios [7];
        int lats [3];
        int nbs [4];
        int trns [3];
        int idx;
        int L;
        logic [63:0] wm;
        ratios = '{1, 2, 3, 5, 8, 16, 20};
        lats   = '{0, 15, 3};
        nbs    = '{1, 4, 0, 2};
        trns   = '{0, 3, 15};

        repeat (4) @(negedge clk);
        // R12 reset state
        check(!mem_clk, "R12 clock low", int'(mem_clk), 0);
        check(mem_cs_n, "R12 select idle", int'(mem_cs_n), 1);
        check(mem_adv_n, "R12 address valid idle", int'(mem_adv_n), 1);
        check(!busy, "R12 not busy", int'(busy), 0);
        check(!beat_valid, "R12 no beat", int'(beat_valid), 0);
        rst_n = 1'b1;

        idx = 0;
        for (int ri = 0; ri < 7; ri++) begin
            for (int m = 0; m < 3; m++) begin
                for (int li = 0; li < 3; li++) begin
                    L = lats[li] + 2;
                    case (idx % 3)
                        0:       wm = '0;
                        1:       wm = 64'h1 << L;
                        default: wm = 64'h16 << L;
                    endcase
                    run_burst(ratios[ri], lats[li], trns[(idx / 3) % 3], nbs[idx % 4],
                              (m != 0), (m != 2), wm, (idx % 5) == 2);
                    idx++;
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule